// File: doc/BRIEF.md
# Integer ALU with Immediate Extension

This block is the combinational integer datapath of a load/store processor core. It takes a register operand A, a second operand that comes either from a register or from the 16-bit immediate field of the instruction word, and an operation code. In the same cycle it returns a 32-bit result and a flag that tells the exception logic that a trapping add or subtract produced a signed overflow.

The block widens the immediate itself, and the widening depends on the operation. Arithmetic and compare operations extend the immediate's sign bit. AND, OR and XOR fill the upper bits with zeros. NOR has no immediate form, so it always takes the register operand. Load-upper-immediate reads only the immediate field. The two counting operations read only A. The surrounding pipeline decides when to use the result and when to raise the trap. This block has no clock and holds no state.

Top module: `alu_int_core`

## Requirements
- R1: Op code 0 (trapping add) and op code 2 (trapping subtract) return A+B and A−B modulo 2^32. `ovf_o` is 1 exactly when the signed two's-complement result does not fit in 32 bits.
- R2: Op code 1 (modulo add) and op code 3 (modulo subtract) return the same result as R1. `ovf_o` is always 0 for these codes.
- R3: When `use_imm_i` is 1, op codes 0, 1, 2, 3, 8 and 9 use the immediate sign-extended from bit 15 as operand B. When `use_imm_i` is 0, they use `b_reg_i`.
- R4: When `use_imm_i` is 1, op codes 4 (AND), 5 (OR) and 6 (XOR) use the immediate zero-extended to 32 bits as operand B.
- R5: Op code 7 returns the bitwise NOR of A and `b_reg_i`. The values of `use_imm_i` and `imm_i` have no effect on it.
- R6: Op code 8 returns 1 when A is less than B as signed numbers, and 0 otherwise.
- R7: Op code 9 returns 1 when A is less than B as unsigned numbers, and 0 otherwise.
- R8: Op code 10 returns the immediate in result bits 31:16 and zeros in bits 15:0. A and `b_reg_i` have no effect on it.
- R9: Op code 11 returns the number of consecutive 1 bits in A, counted from bit 31 downward. The result is 32 when A is all ones.
- R10: Op code 12 returns the number of consecutive 0 bits in A, counted from bit 31 downward. The result is 32 when A is zero.
- R11: `ovf_o` is 0 for every op code except 0 and 2. Op codes 13 to 15 return a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Register operand A |
| b_reg_i | input | 32 | Register operand B |
| imm_i | input | 16 | Immediate field from the instruction word |
| use_imm_i | input | 1 | 1 selects the immediate as operand B |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow of a trapping add or subtract |

## Verification
The hardest cases to reach are the exact overflow boundaries of the trapping add and subtract, together with the long runs of equal bits that the counters must see. Examples are A at the most negative value minus a positive immediate, and A holding a single 1 in its lowest bit for the leading-zero count. Uniform random words almost never land on these. So the stimulus draws each operand either at random or from a pool of extreme values and shifted all-ones masks. It also draws immediates with bit 15 set, so that the choice between sign and zero extension shows up in the result.

// File: rtl/alu_int_pkg.sv
package alu_int_pkg;

    typedef enum logic [3:0] {
        OP_ADD_T  = 4'd0,
        OP_ADD_M  = 4'd1,
        OP_SUB_T  = 4'd2,
        OP_SUB_M  = 4'd3,
        OP_AND    = 4'd4,
        OP_OR     = 4'd5,
        OP_XOR    = 4'd6,
        OP_NOR    = 4'd7,
        OP_LT_S   = 4'd8,
        OP_LT_U   = 4'd9,
        OP_UPPER  = 4'd10,
        OP_LEAD1  = 4'd11,
        OP_LEAD0  = 4'd12
    } alu_op_e;

    // Operations whose immediate keeps its sign
    function automatic logic op_signed_imm(input alu_op_e op);
        return (op inside {OP_ADD_T, OP_ADD_M, OP_SUB_T, OP_SUB_M, OP_LT_S, OP_LT_U});
    endfunction

    // Operations whose immediate is padded with zeros
    function automatic logic op_logic_imm(input alu_op_e op);
        return (op inside {OP_AND, OP_OR, OP_XOR});
    endfunction

    // Operations that route through the subtracting adder
    function automatic logic op_subtracts(input alu_op_e op);
        return (op inside {OP_SUB_T, OP_SUB_M, OP_LT_S, OP_LT_U});
    endfunction

endpackage

// File: rtl/alu_opnd_ext.sv
module alu_opnd_ext
    import alu_int_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] b_reg_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] b_eff_o
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_zext;

    assign imm_sext = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
    assign imm_zext = {{PAD_W{1'b0}}, imm_i};

    always_comb begin
        b_eff_o = b_reg_i;
        if (use_imm_i) begin
            if (op_signed_imm(op_i)) begin
                b_eff_o = imm_sext;
            end else if (op_logic_imm(op_i)) begin
                b_eff_o = imm_zext;
            end
        end
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              ovf_o,
    output logic              lt_s_o,
    output logic              lt_u_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_x;
    logic [DATA_W:0]   full;

    assign b_x   = sub_i ? ~b_i : b_i;
    assign full  = {1'b0, a_i} + {1'b0, b_x} + {{DATA_W{1'b0}}, sub_i};
    assign sum_o = full[MSB:0];

    // Same-sign inputs giving an opposite-sign sum
    assign ovf_o  = (a_i[MSB] == b_x[MSB]) && (sum_o[MSB] != a_i[MSB]);
    assign lt_s_o = sum_o[MSB] ^ ovf_o;
    assign lt_u_o = ~full[DATA_W];

endmodule

// File: rtl/alu_lead_cnt.sv
module alu_lead_cnt #(
    parameter int DATA_W     = 32,
    parameter bit COUNT_ONES = 1'b0,
    localparam int CNT_W     = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] val_i,
    output logic [CNT_W-1:0]  cnt_o
);
    always_comb begin
        logic hit;
        hit   = 1'b0;
        cnt_o = CNT_W'(DATA_W);
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (!hit && (val_i[i] != COUNT_ONES)) begin
                cnt_o = CNT_W'(DATA_W - 1 - i);
                hit   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/alu_int_core.sv
module alu_int_core
    import alu_int_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_reg_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    input  logic [3:0]        op_i,
    output logic [DATA_W-1:0] result_o,
    output logic              ovf_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int LOW_W = DATA_W - IMM_W;

    alu_op_e           op;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;
    logic              add_ovf;
    logic              lt_s;
    logic              lt_u;
    logic [CNT_W-1:0]  lead_cnt [2];

    assign op = alu_op_e'(op_i);

    alu_opnd_ext #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_ext (
        .b_reg_i   (b_reg_i),
        .imm_i     (imm_i),
        .use_imm_i (use_imm_i),
        .op_i      (op),
        .b_eff_o   (b_eff)
    );

    alu_addsub #(
        .DATA_W (DATA_W)
    ) u_addsub (
        .a_i    (a_i),
        .b_i    (b_eff),
        .sub_i  (op_subtracts(op)),
        .sum_o  (sum),
        .ovf_o  (add_ovf),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    // Index 0 counts leading zeros, index 1 counts leading ones
    for (genvar g = 0; g < 2; g++) begin : g_lead
        alu_lead_cnt #(
            .DATA_W     (DATA_W),
            .COUNT_ONES (g[0])
        ) u_cnt (
            .val_i (a_i),
            .cnt_o (lead_cnt[g])
        );
    end

    always_comb begin
        result_o = '0;
        ovf_o    = 1'b0;
        case (op)
            OP_ADD_T, OP_SUB_T: begin
                result_o = sum;
                ovf_o    = add_ovf;
            end
            OP_ADD_M, OP_SUB_M: result_o = sum;
            OP_AND:   result_o = a_i & b_eff;
            OP_OR:    result_o = a_i | b_eff;
            OP_XOR:   result_o = a_i ^ b_eff;
            OP_NOR:   result_o = ~(a_i | b_reg_i);
            OP_LT_S:  result_o = {{(DATA_W-1){1'b0}}, lt_s};
            OP_LT_U:  result_o = {{(DATA_W-1){1'b0}}, lt_u};
            OP_UPPER: result_o = {imm_i, {LOW_W{1'b0}}};
            OP_LEAD1: result_o = {{(DATA_W-CNT_W){1'b0}}, lead_cnt[1]};
            OP_LEAD0: result_o = {{(DATA_W-CNT_W){1'b0}}, lead_cnt[0]};
            default:  result_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_int_core_chk.sv
module alu_int_core_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_reg_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic              use_imm_i,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] result_o,
    input logic              ovf_o
);
    localparam int LOW_W = DATA_W - IMM_W;

    always_comb begin
        // R2, R11: only the trapping forms may raise the flag
        p_no_overflow_r2: assert (!ovf_o || op_i == 4'd0 || op_i == 4'd2)
            else $error("overflow flagged for op %0d", op_i);

        // R1: register add, the result minus B gives back A
        if (op_i == 4'd0 && !use_imm_i) begin
            p_add_inverse_r1: assert (result_o - b_reg_i == a_i)
                else $error("add result inconsistent");
        end

        // R6, R7: compares yield only 0 or 1
        if (op_i == 4'd8 || op_i == 4'd9) begin
            p_lt_binary_r6: assert (result_o[DATA_W-1:1] == '0)
                else $error("compare result not binary");
        end

        // R8: upper immediate placement
        if (op_i == 4'd10) begin
            p_upper_place_r8: assert (result_o[LOW_W-1:0] == '0 &&
                                      result_o[DATA_W-1:LOW_W] == imm_i)
                else $error("upper immediate misplaced");
        end

        // R4: AND with immediate cannot set upper bits
        if (op_i == 4'd4 && use_imm_i) begin
            p_and_zext_r4: assert (result_o[DATA_W-1:IMM_W] == '0)
                else $error("AND immediate not zero-extended");
        end

        // R5: NOR clears every bit set in A
        if (op_i == 4'd7) begin
            p_nor_clear_r5: assert ((result_o & a_i) == '0)
                else $error("NOR kept a bit of A");
        end

        // R10: count never exceeds width
        if (op_i == 4'd12 || op_i == 4'd11) begin
            p_count_range_r10: assert (result_o <= DATA_W)
                else $error("count out of range");
        end

        // R11: undefined codes give zero
        if (op_i > 4'd12) begin
            p_undef_zero_r11: assert (result_o == '0)
                else $error("undefined op produced data");
        end
    end

endmodule

bind alu_int_core alu_int_core_chk #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
) u_chk (
    .a_i       (a_i),
    .b_reg_i   (b_reg_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .op_i      (op_i),
    .result_o  (result_o),
    .ovf_o     (ovf_o)
);

// File: tb/alu_int_core_tb.sv
module alu_int_core_tb;

    logic        clk = 1'b0;
    logic [31:0] a;
    logic [31:0] b_reg;
    logic [15:0] imm;
    logic        use_imm;
    logic [3:0]  op;
    logic [31:0] result;
    logic        ovf;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    alu_int_core u_dut (
        .a_i       (a),
        .b_reg_i   (b_reg),
        .imm_i     (imm),
        .use_imm_i (use_imm),
        .op_i      (op),
        .result_o  (result),
        .ovf_o     (ovf)
    );

    function automatic logic [31:0] pick_b(input logic [3:0] o, input logic [31:0] br,
                                           input logic [15:0] im, input logic ui);
        if (!ui || o == 4'd7) return br;
        if (o == 4'd4 || o == 4'd5 || o == 4'd6) return {16'h0, im};
        return {{16{im[15]}}, im};
    endfunction

    function automatic logic [32:0] model(input logic [3:0] o, input logic [31:0] av,
                                          input logic [31:0] br, input logic [15:0] im,
                                          input logic ui);
        logic [31:0] bv;
        longint      sa, sb, s;
        logic [31:0] r;
        logic        v;
        int          n;
        bv = pick_b(o, br, im, ui);
        sa = longint'($signed(av));
        sb = longint'($signed(bv));
        r  = 32'h0;
        v  = 1'b0;
        case (o)
            4'd0, 4'd1: begin
                s = sa + sb; r = av + bv;
                v = (o == 4'd0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4'd2, 4'd3: begin
                s = sa - sb; r = av - bv;
                v = (o == 4'd2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4'd4: r = av & bv;
            4'd5: r = av | bv;
            4'd6: r = av ^ bv;
            4'd7: r = ~(av | br);
            4'd8: r = (sa < sb) ? 32'd1 : 32'd0;
            4'd9: r = (av < bv) ? 32'd1 : 32'd0;
            4'd10: r = {im, 16'h0};
            4'd11, 4'd12: begin
                n = 0;
                while (n < 32 && av[31-n] == (o == 4'd11)) n++;
                r = 32'(n);
            end
            default: r = 32'h0;
        endcase
        return {v, r};
    endfunction

    function automatic string tag_of(input logic [3:0] o, input logic ui);
        case (o)
            4'd0, 4'd2: return ui ? "R3" : "R1";
            4'd1, 4'd3: return ui ? "R3" : "R2";
            4'd4, 4'd5, 4'd6: return ui ? "R4" : "R11";
            4'd7: return "R5";
            4'd8: return ui ? "R3" : "R6";
            4'd9: return ui ? "R3" : "R7";
            4'd10: return "R8";
            4'd11: return "R9";
            4'd12: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic apply(input logic [3:0] o, input logic [31:0] av, input logic [31:0] br,
                         input logic [15:0] im, input logic ui, input string tag);
        logic [32:0] exp;
        @(negedge clk);
        op = o; a = av; b_reg = br; imm = im; use_imm = ui;
        #2;
        exp = model(o, av, br, im, ui);
        checks++;
        if ({ovf, result} !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h ui=%0b: got ovf=%0b res=%h, expected ovf=%0b res=%h",
                     tag, o, av, br, im, ui, ovf, result, exp[32], exp[31:0]);
        end
    endtask

    function automatic logic [31:0] pick_word(input int unsigned sel, input int unsigned rnd);
        case (sel % 8)
            0: return 32'h0;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            4: return 32'hFFFF_FFFF >> (rnd % 33);
            5: return ~(32'hFFFF_FFFF >> (rnd % 33));
            default: return rnd;
        endcase
    endfunction

    initial begin
        int unsigned seed_junk;
        op = 4'd0; a = '0; b_reg = '0; imm = '0; use_imm = 1'b0;
        seed_junk = $urandom(32'd20240611);

        // Idle state with zero inputs: add of zeros
        apply(4'd0, 32'h0, 32'h0, 16'h0, 1'b0, "R1");
        // R1 overflow corners
        apply(4'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, "R1");
        apply(4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 1'b0, "R1");
        apply(4'd2, 32'h0, 32'h8000_0000, 16'h0, 1'b0, "R1");
        apply(4'd2, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, "R1");
        // R2 same sums never flag
        apply(4'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, "R2");
        apply(4'd3, 32'h8000_0000, 32'h1, 16'h0, 1'b0, "R2");
        // R3 sign extension of immediate
        apply(4'd0, 32'h8000_0000, 32'h0, 16'hFFFF, 1'b1, "R3");
        apply(4'd9, 32'h0000_0005, 32'h0, 16'h8000, 1'b1, "R3");
        apply(4'd8, 32'h0000_0005, 32'h0, 16'h8000, 1'b1, "R3");
        // R4 zero extension
        apply(4'd5, 32'h0, 32'hDEAD_BEEF, 16'h8001, 1'b1, "R4");
        apply(4'd6, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 1'b1, "R4");
        // R5 immediate ignored for NOR
        apply(4'd7, 32'h0F0F_0000, 32'h00F0_00FF, 16'hFFFF, 1'b1, "R5");
        // R6 / R7
        apply(4'd8, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, "R6");
        apply(4'd9, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, "R7");
        // R8
        apply(4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hA5C3, 1'b0, "R8");
        // R9 / R10 boundaries
        apply(4'd11, 32'hFFFF_FFFF, 32'h0, 16'h0, 1'b0, "R9");
        apply(4'd11, 32'h7FFF_FFFF, 32'h0, 16'h0, 1'b0, "R9");
        apply(4'd12, 32'h0, 32'h0, 16'h0, 1'b0, "R10");
        apply(4'd12, 32'h0000_0001, 32'h0, 16'h0, 1'b0, "R10");
        // R11 undefined codes
        apply(4'd15, 32'h1234_5678, 32'h9ABC_DEF0, 16'h1111, 1'b1, "R11");

        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  o;
            logic        ui;
            logic [31:0] av, br;
            logic [15:0] im;
            o  = 4'($urandom % 16);
            ui = 1'($urandom);
            av = pick_word($urandom, $urandom);
            br = pick_word($urandom, $urandom);
            im = 16'(pick_word($urandom, $urandom));
            apply(o, av, br, im, ui, tag_of(o, ui));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule